// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side. The first is a global predictor: a table of 2-bit saturating counters addressed by a shift register that holds the outcomes of the most recent branches. The second is a two-level local predictor. Its first level keeps a per-address history of outcomes, and that history addresses a table of 3-bit saturating counters. A third table of 2-bit chooser counters, addressed by the same global history, decides which of the two component predictions becomes the final prediction.

The fetch side presents a PC. In the same cycle, through combinational reads of the stored state, it gets back the final prediction, both component predictions and the chooser's pick. The resolve side presents the branch PC, the actual outcome and the two component predictions that were recorded at fetch.

On resolve, the block does four things:
- It trains both component counters.
- It moves the chooser one step toward the component that alone was correct.
- It shifts the outcome into the local history entry of that PC.
- It shifts the outcome into the global history.

All histories are kept non-speculatively: they change only on resolve.

Top module: `tourn_bp`

## Requirements
- R1: After reset, every fetch returns not-taken from both components and from the final prediction, and the chooser output (`pred_use_global`) is 0, meaning the local side is chosen.
- R2: The global prediction is the upper bit of a 2-bit counter, taken when the counter is 2 or 3. The counter is addressed by the 12-bit global history, in which bit 0 is the newest outcome and 1 means taken.
- R3: The local prediction reads the 10-bit history entry selected by PC bits [11:2]. That history addresses a table of 3-bit counters, and the prediction is taken when the addressed counter is 4 or more.
- R4: Every counter saturates at 0 and at its maximum and moves by exactly one step. On every resolve, both the global counter and the local counter addressed at that moment are trained toward the actual outcome.
- R5: On every resolve, the global history shifts left and takes the actual outcome into bit 0. With no resolve, it is unchanged.
- R6: On resolve, the local history entry of the resolving PC shifts left and takes the outcome into bit 0. Other entries are unchanged.
- R7: The chooser is a 2-bit counter addressed by the global history. Values 2 and 3 select the global side, and values 0 and 1 select the local side. It steps up when only the recorded global prediction was correct and down when only the recorded local prediction was correct. It is unchanged when both were right or both were wrong.
- R8: A chooser at a strong value (0 or 3) needs two disagreements in the same direction before it changes sides.
- R9: When fetch and resolve occur in the same cycle, the fetch outputs reflect the state before that cycle's update. The update is seen from the next cycle on.
- R10: The final prediction equals the component prediction that the chooser selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | PC being fetched |
| pred_taken | output | 1 | Final direction prediction |
| pred_global | output | 1 | Global component prediction |
| pred_local | output | 1 | Local component prediction |
| pred_use_global | output | 1 | Chooser pick: 1 selects the global side |
| resolve_valid | input | 1 | A branch resolves this cycle |
| resolve_pc | input | 32 | PC of the resolving branch |
| resolve_taken | input | 1 | Actual outcome, 1 for taken |
| resolve_gpred | input | 1 | Global prediction recorded at fetch |
| resolve_lpred | input | 1 | Local prediction recorded at fetch |

## Verification
A fetch lookup and a resolve update can land in the same cycle, including on the same PC and the same global history. In that case the read must see the old counters and the old histories, not the ones being written. The bench provokes this by presenting the resolving PC as the fetch PC in many steps, and by driving unrelated fetch and resolve PCs together in a long pseudo-random run. In every such cycle, the outputs are sampled just before the clock edge and compared with a model that still holds the pre-update state. The following idle cycle then confirms that the update has taken effect.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

   // Chooser counter values for the default 2-bit width
   typedef enum logic [1:0] {
      CH_STRONG_LOCAL  = 2'd0,
      CH_WEAK_LOCAL    = 2'd1,
      CH_WEAK_GLOBAL   = 2'd2,
      CH_STRONG_GLOBAL = 2'd3
   } chooser_e;

   // Bundle of fetch-side results
   typedef struct packed {
      logic taken;
      logic use_global;
      logic glob;
      logic loc;
   } pred_t;

   // Value just below the midpoint: weakly not-taken / weakly local
   function automatic int weak_low(input int width);
      return (1 << (width - 1)) - 1;
   endfunction

endpackage

// File: rtl/tp_sat_table.sv
module tp_sat_table #(
   parameter int IDX_W   = 12,
   parameter int CTR_W   = 2,
   parameter int RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CMAX = '1;
   localparam logic [CTR_W-1:0] CMIN = '0;

   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
      $error("tp_sat_table: IDX_W out of range");
   end
   if (CTR_W < 1 || CTR_W > 8) begin : g_bad_ctr
      $error("tp_sat_table: CTR_W out of range");
   end
   if (RST_VAL < 0 || RST_VAL >= (1 << CTR_W)) begin : g_bad_rst
      $error("tp_sat_table: RST_VAL does not fit the counter");
   end

   logic [CTR_W-1:0] mem [DEPTH];
   logic [CTR_W-1:0] cur;
   logic [CTR_W-1:0] nxt;

   assign rd_ctr = mem[rd_idx];
   assign cur    = mem[wr_idx];

   always_comb begin
      nxt = cur;
      if (wr_up && cur != CMAX)       nxt = cur + 1'b1;
      else if (!wr_up && cur != CMIN) nxt = cur - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_W'(RST_VAL);
      end else if (wr_en) begin
         mem[wr_idx] <= nxt;
      end
   end

   // R4: saturation at the top
   a_r4_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_up && cur == CMAX |=> mem[$past(wr_idx)] == CMAX);
   // R4: saturation at the bottom
   a_r4_hold_at_min: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_up && cur == CMIN |=> mem[$past(wr_idx)] == CMIN);
   // R4: one step up
   a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_up && cur != CMAX |=> mem[$past(wr_idx)] == CTR_W'($past(cur) + 1'b1));
   // R4: one step down
   a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_up && cur != CMIN |=> mem[$past(wr_idx)] == CTR_W'($past(cur) - 1'b1));
endmodule

// File: rtl/tp_local_hist.sv
module tp_local_hist #(
   parameter int IDX_W  = 10,
   parameter int HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              upd_en,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic              upd_taken,
   output logic [HIST_W-1:0] upd_hist
);
   localparam int DEPTH = 1 << IDX_W;

   if (HIST_W < 2 || HIST_W > 16) begin : g_bad_hist
      $error("tp_local_hist: HIST_W out of range");
   end
   if (IDX_W < 1 || IDX_W > 14) begin : g_bad_idx
      $error("tp_local_hist: IDX_W out of range");
   end

   logic [HIST_W-1:0] mem [DEPTH];

   assign rd_hist  = mem[rd_idx];
   assign upd_hist = mem[upd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (upd_en) begin
         mem[upd_idx] <= {upd_hist[HIST_W-2:0], upd_taken};
      end
   end

   // R6: newest outcome lands in bit 0 of the resolving entry
   a_r6_newest_bit: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> mem[$past(upd_idx)][0] == $past(upd_taken));
   // R6: older bits move up by one place
   a_r6_older_bits: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> mem[$past(upd_idx)][HIST_W-1:1] == $past(upd_hist[HIST_W-2:0]));
endmodule

// File: rtl/tp_global_hist.sv
module tp_global_hist #(
   parameter int HIST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic              upd_taken,
   output logic [HIST_W-1:0] hist
);
   if (HIST_W < 2 || HIST_W > 16) begin : g_bad_hist
      $error("tp_global_hist: HIST_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist <= '0;
      else if (upd_en) hist <= {hist[HIST_W-2:0], upd_taken};
   end

   // R5: no resolve, no change
   a_r5_hist_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(hist));
   // R5: outcome enters at bit 0
   a_r5_hist_newest: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> hist[0] == $past(upd_taken));
endmodule

// File: rtl/tourn_bp.sv
module tourn_bp
   import tourn_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int GHIST_W = 12,
   parameter int LIDX_W  = 10,
   parameter int LHIST_W = 10,
   parameter int GCTR_W  = 2,
   parameter int LCTR_W  = 3,
   parameter int CH_W    = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_taken,
   output logic            pred_global,
   output logic            pred_local,
   output logic            pred_use_global,
   input  logic            resolve_valid,
   input  logic [PC_W-1:0] resolve_pc,
   input  logic            resolve_taken,
   input  logic            resolve_gpred,
   input  logic            resolve_lpred
);
   localparam int PC_LSB   = 2;
   localparam int GCTR_RST = weak_low(GCTR_W);
   localparam int LCTR_RST = weak_low(LCTR_W);
   localparam int CH_RST   = weak_low(CH_W);

   if (PC_W <= PC_LSB + LIDX_W) begin : g_bad_pc
      $error("tourn_bp: PC_W too small for the local index");
   end
   if (GCTR_W < 2 || LCTR_W < 2 || CH_W < 2) begin : g_bad_ctr
      $error("tourn_bp: counters need at least two bits");
   end

   // Global history, shared by the global table and the chooser
   logic [GHIST_W-1:0] ghist;
   tp_global_hist #(.HIST_W(GHIST_W)) u_ghist (
      .clk(clk), .rst_n(rst_n),
      .upd_en(resolve_valid), .upd_taken(resolve_taken),
      .hist(ghist)
   );

   // First level of the local predictor
   logic [LIDX_W-1:0]  f_lidx, r_lidx;
   logic [LHIST_W-1:0] f_lhist, r_lhist;
   assign f_lidx = fetch_pc[PC_LSB +: LIDX_W];
   assign r_lidx = resolve_pc[PC_LSB +: LIDX_W];

   tp_local_hist #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(f_lidx), .rd_hist(f_lhist),
      .upd_en(resolve_valid), .upd_idx(r_lidx),
      .upd_taken(resolve_taken), .upd_hist(r_lhist)
   );

   // Second level of the local predictor
   logic [LCTR_W-1:0] lctr;
   tp_sat_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .RST_VAL(LCTR_RST)) u_ltab (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(f_lhist), .rd_ctr(lctr),
      .wr_en(resolve_valid), .wr_idx(r_lhist), .wr_up(resolve_taken)
   );

   // Global counter table
   logic [GCTR_W-1:0] gctr;
   tp_sat_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .RST_VAL(GCTR_RST)) u_gtab (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghist), .rd_ctr(gctr),
      .wr_en(resolve_valid), .wr_idx(ghist), .wr_up(resolve_taken)
   );

   // Chooser: trained only on disagreement of correctness
   logic g_ok, l_ok, ch_we;
   assign g_ok  = (resolve_gpred == resolve_taken);
   assign l_ok  = (resolve_lpred == resolve_taken);
   assign ch_we = resolve_valid && (g_ok != l_ok);

   logic [CH_W-1:0] chctr;
   tp_sat_table #(.IDX_W(GHIST_W), .CTR_W(CH_W), .RST_VAL(CH_RST)) u_chtab (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghist), .rd_ctr(chctr),
      .wr_en(ch_we), .wr_idx(ghist), .wr_up(g_ok)
   );

   // Fetch-side results
   pred_t pred;
   always_comb begin
      pred.glob       = gctr[GCTR_W-1];
      pred.loc        = lctr[LCTR_W-1];
      pred.use_global = chctr[CH_W-1];
      pred.taken      = pred.use_global ? pred.glob : pred.loc;
   end

   assign pred_taken      = pred.taken;
   assign pred_global     = pred.glob;
   assign pred_local      = pred.loc;
   assign pred_use_global = pred.use_global;

   wire unused_pc_bits = ^{fetch_pc[PC_W-1:PC_LSB+LIDX_W], fetch_pc[PC_LSB-1:0],
                           resolve_pc[PC_W-1:PC_LSB+LIDX_W], resolve_pc[PC_LSB-1:0]};

   // R7: with no disagreement and no change in history, the chooser pick holds
   a_r7_chooser_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_valid && !ch_we && resolve_taken == ghist[GHIST_W-1] &&
      ghist == {GHIST_W{resolve_taken}} |=> $stable(pred_use_global));
endmodule

// File: tb/tourn_bp_tb_top.sv
module tourn_bp_tb_top;
   localparam int GH_W   = 12;
   localparam int LI_W   = 10;
   localparam int LH_W   = 10;
   localparam int G_SIZE = 1 << GH_W;
   localparam int L_SIZE = 1 << LI_W;
   localparam int C_SIZE = 1 << LH_W;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_taken, pred_global, pred_local, pred_use_global;
   logic        resolve_valid = 1'b0;
   logic [31:0] resolve_pc = '0;
   logic        resolve_taken = 1'b0;
   logic        resolve_gpred = 1'b0;
   logic        resolve_lpred = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   tourn_bp dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_taken(pred_taken), .pred_global(pred_global),
      .pred_local(pred_local), .pred_use_global(pred_use_global),
      .resolve_valid(resolve_valid), .resolve_pc(resolve_pc),
      .resolve_taken(resolve_taken), .resolve_gpred(resolve_gpred),
      .resolve_lpred(resolve_lpred)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // Reference model state
   int m_g [G_SIZE];
   int m_c [G_SIZE];
   int m_lh [L_SIZE];
   int m_lc [C_SIZE];
   int m_gh;

   function automatic int sat(input int v, input bit up, input int maxv);
      if (up) return (v < maxv) ? v + 1 : v;
      return (v > 0) ? v - 1 : v;
   endfunction

   function automatic int lidx(input logic [31:0] pc);
      return int'(pc[LI_W+1:2]);
   endfunction

   // {taken, use_global, global, local}
   function automatic logic [3:0] model_pred(input logic [31:0] pc);
      logic g, l, u;
      g = (m_g[m_gh] >= 2);
      l = (m_lc[m_lh[lidx(pc)]] >= 4);
      u = (m_c[m_gh] >= 2);
      return {u ? g : l, u, g, l};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < G_SIZE; i++) begin m_g[i] = 1; m_c[i] = 1; end
      for (int i = 0; i < L_SIZE; i++) m_lh[i] = 0;
      for (int i = 0; i < C_SIZE; i++) m_lc[i] = 3;
      m_gh = 0;
   endtask

   task automatic model_resolve(input logic [31:0] pc, input bit t, input bit gp, input bit lp);
      int li, h;
      li = lidx(pc);
      h  = m_lh[li];
      m_g[m_gh] = sat(m_g[m_gh], t, 3);
      m_lc[h]   = sat(m_lc[h], t, 7);
      if ((gp == t) != (lp == t)) m_c[m_gh] = sat(m_c[m_gh], gp == t, 3);
      m_lh[li] = ((h << 1) | int'(t)) & (L_SIZE - 1);
      m_gh     = ((m_gh << 1) | int'(t)) & (G_SIZE - 1);
   endtask

   task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act={t,u,g,l}=%b exp=%b", tag, act, exp);
      end
   endtask

   task automatic check1(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act=%b exp=%b", tag, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, compare before the rising edge, then update the model
   task automatic step(input logic [31:0] fpc, input bit rv, input logic [31:0] rpc,
                       input bit rt, input bit gp, input bit lp, input string tag);
      @(negedge clk);
      fetch_pc = fpc; resolve_valid = rv; resolve_pc = rpc;
      resolve_taken = rt; resolve_gpred = gp; resolve_lpred = lp;
      #1;
      check4(tag, {pred_taken, pred_use_global, pred_global, pred_local}, model_pred(fpc));
      @(posedge clk);
      if (rv) model_resolve(rpc, rt, gp, lp);
   endtask

   // Fetch and resolve of the same PC in one cycle, with predictions taken from the outputs
   task automatic fr(input logic [31:0] pc, input bit t, input string tag);
      logic [3:0] p;
      p = model_pred(pc);
      step(pc, 1'b1, pc, t, p[1], p[0], tag);
   endtask

   task automatic idle(input logic [31:0] pc, input string tag);
      step(pc, 1'b0, pc, 1'b0, 1'b0, 1'b0, tag);
   endtask

   task automatic t_reset();
      @(negedge clk);
      #1;
      check4("R1 reset pc0", {pred_taken, pred_use_global, pred_global, pred_local}, 4'b0000);
      fetch_pc = 32'h0000_0ffc; #1;
      check4("R1 reset pc_hi", {pred_taken, pred_use_global, pred_global, pred_local}, 4'b0000);
      idle(32'h1234_5678, "R1 reset pc_any");
      idle(32'h0000_0040, "R5 idle keeps state");
   endtask

   task automatic t_global();
      // Repeated taken on different PCs: the global history walks, the counter trains (R2, R5)
      for (int i = 0; i < 16; i++) fr(32'h100 + 32'(i * 4), 1'b1, "R2 global train");
      idle(32'h500, "R2 global after all-taken history");
      check1("R2 global predicts taken at saturated history", pred_global, 1'b1);
      for (int i = 0; i < 14; i++) fr(32'h200, 1'b0, "R5 history clears");
      idle(32'h300, "R5 idle after clear");
   endtask

   task automatic t_local();
      // Loop-like pattern on one PC: TTTN (R3, R6)
      for (int r = 0; r < 30; r++) begin
         fr(32'h0000_0880, 1'b1, "R3 loop T");
         fr(32'h0000_0880, 1'b1, "R3 loop T");
         fr(32'h0000_0880, 1'b1, "R3 loop T");
         fr(32'h0000_0880, 1'b0, "R6 loop N");
      end
      // An aliasing PC shares the entry (same bits 11:2)
      idle(32'h0001_0880, "R3 alias reads same entry");
      idle(32'h0000_0884, "R6 neighbour entry untouched");
   endtask

   task automatic t_saturate();
      for (int i = 0; i < 24; i++) fr(32'h0000_0a00, 1'b1, "R4 saturate up");
      fr(32'h0000_0a00, 1'b0, "R4 one not-taken");
      idle(32'h0000_0a00, "R4 after one down step");
      for (int i = 0; i < 24; i++) fr(32'h0000_0a00, 1'b0, "R4 saturate down");
      idle(32'h0000_0a00, "R4 bottom");
   endtask

   task automatic t_chooser();
      // All not-taken keeps the history at zero so one chooser entry is reused
      for (int i = 0; i < 14; i++) step(32'h40, 1'b1, 32'h40, 1'b0, 1'b0, 1'b0, "R7 both right");
      idle(32'h40, "R7 both right leaves chooser");
      check1("R7 chooser still local", pred_use_global, 1'b0);
      // Only local right, three times: chooser at strong local
      for (int i = 0; i < 3; i++) step(32'h40, 1'b1, 32'h40, 1'b0, 1'b1, 1'b0, "R7 local wins");
      idle(32'h40, "R7 at strong local");
      check1("R7 strong local picks local", pred_use_global, 1'b0);
      // One global win from strong: still local
      step(32'h40, 1'b1, 32'h40, 1'b0, 1'b0, 1'b1, "R8 first global win");
      idle(32'h40, "R8 after one win");
      check1("R8 one win does not switch", pred_use_global, 1'b0);
      // Second global win: switches
      step(32'h40, 1'b1, 32'h40, 1'b0, 1'b0, 1'b1, "R8 second global win");
      idle(32'h40, "R8 after two wins");
      check1("R8 two wins switch to global", pred_use_global, 1'b1);
      // Both wrong: no movement
      for (int i = 0; i < 3; i++) step(32'h40, 1'b1, 32'h40, 1'b0, 1'b1, 1'b1, "R7 both wrong");
      idle(32'h40, "R7 both wrong leaves chooser");
      check1("R7 both wrong keeps global", pred_use_global, 1'b1);
      check1("R10 final follows global side", pred_taken, pred_global);
   endtask

   task automatic t_same_cycle();
      // Fetch and resolve on the same PC and history; outputs must show the old state (R9)
      for (int i = 0; i < 6; i++) begin
         fr(32'h0000_0c40, 1'b1, "R9 same-cycle read old");
         idle(32'h0000_0c40, "R9 next cycle sees update");
      end
   endtask

   task automatic t_mixed();
      logic [15:0] lfsr;
      logic [31:0] pcs [8];
      logic [31:0] fp, rp;
      bit rv, rt;
      logic [3:0] p;
      lfsr = 16'hace1;
      pcs[0] = 32'h0000_0100; pcs[1] = 32'h0000_0104; pcs[2] = 32'h0000_1100;
      pcs[3] = 32'h0000_0ffc; pcs[4] = 32'h0000_2000; pcs[5] = 32'h0000_0008;
      pcs[6] = 32'h0004_0104; pcs[7] = 32'h0000_0abc;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         fp = pcs[lfsr[2:0]];
         rp = pcs[lfsr[5:3]];
         rv = lfsr[6] | lfsr[9];
         rt = (lfsr[3:0] != 4'd0) ? lfsr[7] ^ lfsr[8] ^ lfsr[0] : 1'b1;
         p  = model_pred(rp);
         step(fp, rv, rp, rt, lfsr[11] ? ~p[1] : p[1], p[0], "R10 mixed traffic");
      end
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_global();
      t_local();
      t_saturate();
      t_chooser();
      t_same_cycle();
      t_mixed();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule